// File: doc/BRIEF.md
# Serial EEPROM Burst Read Controller

This block reads a run of consecutive 16-bit words from a three-wire serial EEPROM that has a select line, a serial clock, and one data line in each direction. The host gives a start address and a word count and pulses `start` for one cycle. The controller then runs one complete select transaction for each word. In each transaction it sends a read command, sends the address, and shifts in the reply. Each received word is returned on the host side with a one-cycle strobe and its position within the burst. A one-cycle `done` pulse closes the burst.

Every serial clock phase is timed by a divider counted in system clock cycles. The high phase lasts at least `HI_CYC` cycles and the low phase at least `LO_CYC` cycles. The first cycle of each transaction keeps the select line high for at least `SEL_CYC` cycles. When `RDY_EN` is set, a phase that has run its minimum time does not end until the `ready` input is high. That wait is capped at `RDY_TMO` extra cycles, after which the phase ends anyway. Incoming serial data passes through a two-flop synchronizer before it is sampled. `HI_CYC` must therefore be at least 3.

Top module: `ee_burst_reader`

## Requirements
- R1: While reset is held, and afterwards until a burst starts, `ser_cs`, `ser_clk`, `ser_mosi`, `busy`, `word_valid` and `done` are all low.
- R2: `ser_cs` rises only while `ser_clk` is low. The first serial clock period after select rises (one low phase and one high phase) carries `ser_mosi` = 0 and comes before any command bit.
- R3: The next three rising edges of `ser_clk` carry the read command on `ser_mosi`, in the order 1, 1, 0. `ser_mosi` never changes in the cycle in which `ser_clk` rises.
- R4: The next `ADDR_BITS` rising edges carry the word address, most significant bit first. For the word at burst index i, the address is (start + i) modulo 2^`ADDR_BITS`.
- R5: The transaction then has exactly 17 data periods with `ser_mosi` = 0. Incoming data is sampled at the end of each high phase and shifted in from the right. The first sampled bit is dropped, so the word is formed from the last 16 bits, bit 15 first.
- R6: Each word is presented for exactly one cycle of `word_valid`, with `word_idx` = i. Indices run from 0 to count−1 in order.
- R7: `ser_cs` falls while `ser_clk` is low. It then stays low through exactly one serial clock pulse (a low, high, low sequence) before the next transaction raises it.
- R8: After the last word's deselect sequence, `done` pulses for exactly one cycle and `busy` is low in that cycle. `busy` stays high from the cycle after the accepted start until then.
- R9: Every high phase lasts at least `HI_CYC` cycles and every low phase at least `LO_CYC` cycles. In the first clock period of a transaction, the low phase lasts at least max(`LO_CYC`, `SEL_CYC`−`HI_CYC`) cycles, and select is high for at least `SEL_CYC` cycles before the first falling edge.
- R10: With `RDY_EN` set, a phase whose minimum time has run out is held while `ready` is low. It ends in the cycle after `ready` is seen high.
- R11: If `ready` stays low, each phase ends after exactly its minimum length plus `RDY_TMO` cycles.
- R12: A `start` pulse while `busy` is high has no effect on the running burst's words, their indices, or its single `done`.
- R13: A start with a word count of 0 gives `done` in the next cycle and no activity on `ser_cs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle burst request, accepted only when idle |
| start_addr | input | ADDR_BITS | Address of the first word |
| word_count | input | CNT_W | Number of words to read |
| ready | input | 1 | Phase-stretch input, used when RDY_EN = 1 |
| ser_miso | input | 1 | Serial data from the EEPROM |
| ser_cs | output | 1 | EEPROM select, active high |
| ser_clk | output | 1 | Serial clock |
| ser_mosi | output | 1 | Serial data to the EEPROM |
| busy | output | 1 | Burst in progress |
| word_valid | output | 1 | One-cycle strobe for a received word |
| word_data | output | 16 | Received word |
| word_idx | output | CNT_W | Index of the word within the burst |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
The bench models the EEPROM at its pins. The model decodes the command and the address from the bits it sees at each rising clock edge. It answers with a leading zero followed by a word computed from that address, which shows both that the address was sent correctly and that the 17-bit capture drops the right bit. Random bursts with random start addresses, counts of one to four words, and a randomly toggled `ready` line exercise the sequencing and phase timing under varied stretching. Directed cases separate the remaining behaviours: a burst that wraps past the top address, a long hold of `ready` below the timeout (stretching) against a permanent low (timeout), a zero count, and a start pulse injected during a burst.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_DESEL
    } ee_state_t;

    // start bit followed by the two-bit read opcode, sent left to right
    localparam logic [2:0] RD_OP   = 3'b110;
    localparam int         WORD_W  = 16;
    localparam int         RX_BITS = WORD_W + 1;
    localparam int         BCNT_W  = 5;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ee_sync2.sv
module ee_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) stage <= 2'b00;
        else     stage <= {stage[0], d_in};
    end

    assign d_out = stage[1];
endmodule

// File: rtl/ee_phase_timer.sv
module ee_phase_timer #(
    parameter int LEN_W   = 8,
    parameter int RDY_EN  = 1,
    parameter int RDY_TMO = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [LEN_W-1:0] len,
    input  logic             ready,
    output logic             phase_done
);
    localparam int TMO_W = $clog2(RDY_TMO + 1) + 1;

    logic [LEN_W-1:0] cnt;
    logic             at_end;
    logic             gate;

    assign at_end     = (cnt == LEN_W'(len - 1'b1));
    assign phase_done = run && at_end && gate;

    always_ff @(posedge clk) begin
        if (rst || !run || phase_done) cnt <= '0;
        else if (!at_end)              cnt <= cnt + 1'b1;
    end

    generate
        if (RDY_EN != 0) begin : g_wait
            logic [TMO_W-1:0] wcnt;
            assign gate = ready || (wcnt == TMO_W'(RDY_TMO));
            always_ff @(posedge clk) begin
                if (rst || !run || phase_done) wcnt <= '0;
                else if (at_end)               wcnt <= wcnt + 1'b1;
            end
        end else begin : g_nowait
            assign gate = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/ee_rx_shift.sv
module ee_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word_out
);
    always_ff @(posedge clk) begin
        if (rst)           word_out <= '0;
        else if (shift_en) word_out <= {word_out[W-2:0], bit_in};
    end
endmodule

// File: rtl/ee_burst_reader.sv
module ee_burst_reader
    import ee_rd_pkg::*;
#(
    parameter int ADDR_BITS = 6,
    parameter int CNT_W     = 8,
    parameter int HI_CYC    = 94,
    parameter int LO_CYC    = 32,
    parameter int SEL_CYC   = 125,
    parameter int RDY_EN    = 1,
    parameter int RDY_TMO   = 1000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [ADDR_BITS-1:0] start_addr,
    input  logic [CNT_W-1:0]     word_count,
    input  logic                 ready,
    input  logic                 ser_miso,
    output logic                 ser_cs,
    output logic                 ser_clk,
    output logic                 ser_mosi,
    output logic                 busy,
    output logic                 word_valid,
    output logic [WORD_W-1:0]    word_data,
    output logic [CNT_W-1:0]     word_idx,
    output logic                 done
);
    localparam int SEL_LO = imax(LO_CYC, SEL_CYC - HI_CYC);
    localparam int MAXLEN = imax(imax(HI_CYC, LO_CYC), SEL_LO);
    localparam int LEN_W  = $clog2(MAXLEN + 1);

    ee_state_t            state;
    logic                 cs_r, clk_r, mosi_r;
    logic [BCNT_W-1:0]    bcnt;
    logic [ADDR_BITS-1:0] addr_r, a_sh;
    logic [2:0]           op_sh;
    logic [CNT_W-1:0]     widx, last_idx, idx_r;
    logic                 valid_r, done_r;
    logic [LEN_W-1:0]     phase_len;
    logic                 pdone, miso_s, shift_en;

    always_comb begin
        if (clk_r)                phase_len = LEN_W'(HI_CYC);
        else if (state == ST_SEL) phase_len = LEN_W'(SEL_LO);
        else                      phase_len = LEN_W'(LO_CYC);
    end

    ee_phase_timer #(.LEN_W(LEN_W), .RDY_EN(RDY_EN), .RDY_TMO(RDY_TMO)) u_timer (
        .clk(clk), .rst(rst), .run(state != ST_IDLE), .len(phase_len),
        .ready(ready), .phase_done(pdone)
    );

    ee_sync2 u_sync (.clk(clk), .rst(rst), .d_in(ser_miso), .d_out(miso_s));

    assign shift_en = (state == ST_DATA) && clk_r && pdone;

    ee_rx_shift #(.W(WORD_W)) u_rx (
        .clk(clk), .rst(rst), .shift_en(shift_en), .bit_in(miso_s), .word_out(word_data)
    );

    always_ff @(posedge clk) begin
        valid_r <= 1'b0;
        done_r  <= 1'b0;
        if (rst) begin
            state    <= ST_IDLE;
            cs_r     <= 1'b0;
            clk_r    <= 1'b0;
            mosi_r   <= 1'b0;
            bcnt     <= '0;
            addr_r   <= '0;
            a_sh     <= '0;
            op_sh    <= '0;
            widx     <= '0;
            last_idx <= '0;
            idx_r    <= '0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                if (word_count == '0) begin
                    done_r <= 1'b1;
                end else begin
                    state    <= ST_SEL;
                    cs_r     <= 1'b1;
                    addr_r   <= start_addr;
                    widx     <= '0;
                    last_idx <= word_count - 1'b1;
                end
            end
        end else if (pdone) begin
            if (state != ST_DESEL && !clk_r) begin
                clk_r <= 1'b1;
            end else begin
                unique case (state)
                    ST_SEL: begin
                        clk_r  <= 1'b0;
                        state  <= ST_CMD;
                        bcnt   <= '0;
                        mosi_r <= RD_OP[2];
                        op_sh  <= RD_OP << 1;
                        a_sh   <= addr_r;
                    end
                    ST_CMD: begin
                        clk_r <= 1'b0;
                        if (bcnt == BCNT_W'(2)) begin
                            state  <= ST_ADDR;
                            bcnt   <= '0;
                            mosi_r <= a_sh[ADDR_BITS-1];
                            a_sh   <= a_sh << 1;
                        end else begin
                            bcnt   <= bcnt + 1'b1;
                            mosi_r <= op_sh[2];
                            op_sh  <= op_sh << 1;
                        end
                    end
                    ST_ADDR: begin
                        clk_r <= 1'b0;
                        if (bcnt == BCNT_W'(ADDR_BITS - 1)) begin
                            state  <= ST_DATA;
                            bcnt   <= '0;
                            mosi_r <= 1'b0;
                        end else begin
                            bcnt   <= bcnt + 1'b1;
                            mosi_r <= a_sh[ADDR_BITS-1];
                            a_sh   <= a_sh << 1;
                        end
                    end
                    ST_DATA: begin
                        clk_r <= 1'b0;
                        if (bcnt == BCNT_W'(RX_BITS - 1)) begin
                            valid_r <= 1'b1;
                            idx_r   <= widx;
                            state   <= ST_DESEL;
                            cs_r    <= 1'b0;
                            bcnt    <= '0;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    ST_DESEL: begin
                        if (bcnt == BCNT_W'(0)) begin
                            clk_r <= 1'b1;
                            bcnt  <= BCNT_W'(1);
                        end else if (bcnt == BCNT_W'(1)) begin
                            clk_r <= 1'b0;
                            bcnt  <= BCNT_W'(2);
                        end else if (widx == last_idx) begin
                            state  <= ST_IDLE;
                            done_r <= 1'b1;
                        end else begin
                            state  <= ST_SEL;
                            cs_r   <= 1'b1;
                            bcnt   <= '0;
                            widx   <= widx + 1'b1;
                            addr_r <= addr_r + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign ser_cs     = cs_r;
    assign ser_clk    = clk_r;
    assign ser_mosi   = mosi_r;
    assign busy       = (state != ST_IDLE);
    assign word_valid = valid_r;
    assign word_idx   = idx_r;
    assign done       = done_r;
endmodule

// File: rtl/ee_burst_reader_chk.sv
module ee_burst_reader_chk #(
    parameter int CNT_W  = 8,
    parameter int HI_CYC = 94
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CNT_W-1:0] word_count,
    input logic             ser_cs,
    input logic             ser_clk,
    input logic             ser_mosi,
    input logic             busy,
    input logic             word_valid,
    input logic             done
);
    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)          hi_run <= '0;
        else if (ser_clk) hi_run <= (hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1;
        else              hi_run <= '0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_cs && !ser_clk));  // R1
    AST_CS_RISE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_cs) |-> !ser_clk);  // R2
    AST_MOSI_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk) |-> $stable(ser_mosi));  // R3
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);  // R6
    AST_CS_FALL_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_cs) |-> !ser_clk);  // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy ##1 !done));  // R8
    AST_HIGH_MIN: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_clk) |-> (hi_run >= 16'(HI_CYC)));  // R9
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && word_count == '0) |=> (done && !ser_cs));  // R13
endmodule

bind ee_burst_reader ee_burst_reader_chk #(.CNT_W(CNT_W), .HI_CYC(HI_CYC)) u_chk (
    .clk(clk), .rst(rst), .start(start), .word_count(word_count),
    .ser_cs(ser_cs), .ser_clk(ser_clk), .ser_mosi(ser_mosi), .busy(busy),
    .word_valid(word_valid), .done(done)
);

// File: tb/test_ee_burst_reader.sv
`timescale 1ns/1ps
module test_ee_burst_reader;
    localparam int AB     = 6;
    localparam int CW     = 4;
    localparam int HI     = 5;
    localparam int LO     = 3;
    localparam int SELC   = 12;
    localparam int SEL_LO = (LO > SELC - HI) ? LO : SELC - HI;
    localparam int TMO    = 40;
    localparam int RX_END = 4 + AB + 17;

    logic          clk = 1'b0, rst = 1'b1, start = 1'b0, ready = 1'b1, ser_miso = 1'b1;
    logic [AB-1:0] start_addr = '0;
    logic [CW-1:0] word_count = '0;
    logic          ser_cs, ser_clk, ser_mosi, busy, word_valid, done;
    logic [15:0]   word_data;
    logic [CW-1:0] word_idx;

    always #4 clk = ~clk;

    ee_burst_reader #(.ADDR_BITS(AB), .CNT_W(CW), .HI_CYC(HI), .LO_CYC(LO),
                      .SEL_CYC(SELC), .RDY_EN(1), .RDY_TMO(TMO)) i_ee_burst_reader (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .word_count(word_count), .ready(ready), .ser_miso(ser_miso),
        .ser_cs(ser_cs), .ser_clk(ser_clk), .ser_mosi(ser_mosi), .busy(busy),
        .word_valid(word_valid), .word_data(word_data), .word_idx(word_idx), .done(done)
    );

    int nvec = 0, nerr = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] mem(input logic [AB-1:0] a);
        logic [31:0] t;
        t = (32'(a) * 32'd40503 + 32'd12345) ^ (32'(a) << 9);
        return t[15:0] ^ 16'hA5C3;
    endfunction

    // monitor and EEPROM model state
    int          rise_n = 0, hi_len = 0, lo_len = 0, cs_cyc = 0, desel_r = 0;
    int          exp_i = 0, exp_cnt = 0, words = 0, dones = 0;
    bit          first_word = 1'b1, p_clk = 1'b0, p_cs = 1'b0;
    logic [AB-1:0] exp_start = '0, rx_addr = '0;
    logic [15:0] dev_w = '0;
    int          rdy_mode = 0;

    always @(negedge clk) begin
        if (rst) begin
            p_clk = 1'b0; p_cs = 1'b0; hi_len = 0; lo_len = 0;
        end else begin
            if (ser_cs && !p_cs) begin
                chk(!ser_clk, "R2 clock low at select rise", int'(ser_clk), 0);
                if (!first_word) chk(desel_r == 1, "R7 deselect pulses", desel_r, 1);
                first_word = 1'b0;
                rise_n = 0;
                cs_cyc = 0;
            end
            if (!ser_cs && p_cs) begin
                chk(!ser_clk, "R7 clock low at select fall", int'(ser_clk), 0);
                chk(rise_n == RX_END, "R5 edges per transaction", rise_n, RX_END);
                desel_r = 0;
                ser_miso = 1'b1;
            end
            if (ser_clk && !p_clk) begin
                if (ser_cs) begin
                    rise_n++;
                    chk(lo_len >= ((rise_n == 1) ? SEL_LO : LO), "R9 low phase", lo_len,
                        (rise_n == 1) ? SEL_LO : LO);
                    if (rise_n == 1) begin
                        chk(ser_mosi == 1'b0, "R2 dummy period data", int'(ser_mosi), 0);
                    end else if (rise_n <= 4) begin
                        chk(ser_mosi == ((rise_n == 4) ? 1'b0 : 1'b1), "R3 command bit",
                            int'(ser_mosi), (rise_n == 4) ? 0 : 1);
                    end else if (rise_n <= 4 + AB) begin
                        rx_addr = {rx_addr[AB-2:0], ser_mosi};
                        if (rise_n == 4 + AB) begin
                            chk(rx_addr == AB'(exp_start + AB'(exp_i)), "R4 address",
                                int'(rx_addr), int'(AB'(exp_start + AB'(exp_i))));
                            dev_w = mem(rx_addr);
                        end
                    end else begin
                        automatic int j = rise_n - 4 - AB;
                        chk(ser_mosi == 1'b0, "R5 data in idle", int'(ser_mosi), 0);
                        chk(j <= 17, "R5 data periods", j, 17);
                        if (j == 1)       ser_miso = 1'b0;
                        else if (j <= 17) ser_miso = dev_w[17-j];
                    end
                end else begin
                    desel_r++;
                end
            end
            if (!ser_clk && p_clk) begin
                chk(hi_len >= HI, "R9 high phase", hi_len, HI);
                if (ser_cs && rise_n == 1) chk(cs_cyc >= SELC, "R9 select hold", cs_cyc, SELC);
            end
            if (word_valid) begin
                chk(word_data == mem(AB'(exp_start + AB'(exp_i))), "R5 word data",
                    int'(word_data), int'(mem(AB'(exp_start + AB'(exp_i)))));
                chk(int'(word_idx) == exp_i, "R6 word index", int'(word_idx), exp_i);
                exp_i++;
                words++;
            end
            if (done) begin
                chk(exp_i == exp_cnt, "R8 words before done", exp_i, exp_cnt);
                chk(!busy, "R8 idle at done", int'(busy), 0);
                dones++;
            end
            hi_len = ser_clk ? hi_len + 1 : 0;
            lo_len = ser_clk ? 0 : lo_len + 1;
            if (ser_cs) cs_cyc++;
            p_clk = ser_clk;
            p_cs  = ser_cs;
            if (rdy_mode == 1) ready = ($urandom % 4) != 0;
        end
    end

    task automatic begin_burst(input logic [AB-1:0] a, input int n);
        exp_start = a; exp_cnt = n; exp_i = 0; words = 0; dones = 0; first_word = 1'b1;
        @(negedge clk);
        start = 1'b1; start_addr = a; word_count = CW'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_burst(input int n);
        while (dones == 0) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(words == n, "R6 word count", words, n);
        chk(dones == 1, "R8 single done", dones, 1);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nvec++; nerr++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({ser_cs, ser_clk, ser_mosi, busy, word_valid, done} == 6'b0, "R1 reset outputs",
            int'({ser_cs, ser_clk, ser_mosi, busy, word_valid, done}), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk({ser_cs, ser_clk, busy, done} == 4'b0, "R1 idle after reset",
            int'({ser_cs, ser_clk, busy, done}), 0);

        // directed: wrap past top address
        begin_burst(6'd62, 4);
        finish_burst(4);

        // random bursts, with and without ready jitter
        for (int k = 0; k < 12; k++) begin
            automatic int n = 1 + ($urandom % 4);
            rdy_mode = $urandom % 2;
            begin_burst(AB'($urandom), n);
            finish_burst(n);
            rdy_mode = 0;
            ready = 1'b1;
        end

        // R12: start pulse during a burst is ignored
        begin_burst(6'd10, 3);
        repeat (40) @(negedge clk);
        start = 1'b1; start_addr = 6'd50; word_count = '0;
        @(negedge clk);
        start = 1'b0;
        finish_burst(3);
        chk(exp_i == 3, "R12 burst unaffected", exp_i, 3);

        // R13: zero count
        @(negedge clk);
        start = 1'b1; word_count = '0; start_addr = 6'd5;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R13 immediate done", int'(done), 1);
        begin
            automatic int cs_seen = 0;
            for (int t = 0; t < 50; t++) begin
                @(negedge clk);
                if (ser_cs) cs_seen++;
            end
            chk(cs_seen == 0, "R13 no select activity", cs_seen, 0);
        end

        // R10: ready low holds a high phase
        begin_burst(6'd33, 1);
        while (!ser_clk) @(negedge clk);
        ready = 1'b0;
        repeat (20) @(negedge clk);
        chk(ser_clk == 1'b1, "R10 phase held by ready", int'(ser_clk), 1);
        ready = 1'b1;
        repeat (2) @(negedge clk);
        chk(ser_clk == 1'b0, "R10 phase ends after ready", int'(ser_clk), 0);
        finish_burst(1);

        // R11: ready stuck low, phases end on timeout
        ready = 1'b0;
        begin_burst(6'd7, 1);
        while (!ser_clk) @(negedge clk);
        begin
            automatic int h = 0;
            while (ser_clk) begin
                h++;
                @(negedge clk);
            end
            chk(h == HI + TMO, "R11 timeout phase length", h, HI + TMO);
        end
        finish_burst(1);
        ready = 1'b1;

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule